// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock of an I2C controller acting as bus master. A 16-bit baud count sets the length of one clock part, and a 2-bit speed setting chooses whether a full SCL period has two parts or three. In standard timing the line is low for one part and released for one part. In fast and fast-plus timing it is low for two parts and released for one. Alongside the clock level it gives two single-cycle strobes: one marks the cycle in which SDA may be changed, and one marks the cycle in which SDA is to be sampled.

The block watches the sampled SCL line so that a target can stretch the clock. When the block releases SCL but still reads it low, the released part is held and does not count. When a stretch ends, a programmable setup delay of the setup count plus one cycles passes before the released part begins and before the sample strobe fires. Start, stop and byte framing are handled by the logic around this block. The high-speed setting (code 2) is not supported and runs with standard timing.

Top module: `i2cSclGen`

## Requirements
- R1: While `en` is low, `sclOut` is 1 (released) and neither `sdaChange` nor `sdaSample` is asserted.
- R2: One cycle after `en` is first seen high, `sclOut` goes to 0 and `sdaChange` is 1 in that first low cycle. Every later low part also starts with a `sdaChange` cycle.
- R3: With `speedMode` 0 (standard), or 2 (high speed, which falls back to standard timing), and no stretch, SCL is low for B cycles and released for B cycles, where B is the effective baud count.
- R4: With `speedMode` 1 (fast) or 3 (fast plus) and no stretch, SCL is low for 2·B cycles and released for B cycles.
- R5: A `baudCount` of 0 gives the same timing as a `baudCount` of 1.
- R6: If `sclIn` reads 0 in the first released cycle, SCL stays released and the released part does not count while `sclIn` stays 0. No sample strobe is given during the stretch.
- R7: After a stretch, the first clock edge that sees `sclIn` at 1 is followed by `setupCount`+1 setup cycles. Then comes the released part of B cycles, and `sdaSample` fires in its first cycle. A setup count of 0 still inserts one cycle.
- R8: Without a stretch, `sdaSample` fires in the first released cycle. `sdaChange` occurs only while SCL is driven low, `sdaSample` only while SCL is released and read high, and the two are never asserted together. Each occurs exactly once per period.
- R9: Dropping `en` at any point returns `sclOut` to 1, with no strobes, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run the clock generator |
| speedMode | input | 2 | 0 standard, 1 fast, 2 high speed (treated as standard), 3 fast plus |
| baudCount | input | 16 | Length of one clock part in cycles (0 acts as 1) |
| setupCount | input | 16 | Setup delay after a stretch, in cycles minus one |
| sclIn | input | 1 | Sampled SCL line level |
| sclOut | output | 1 | SCL drive: 0 drives low, 1 releases |
| sdaChange | output | 1 | Single-cycle strobe: SDA may change |
| sdaSample | output | 1 | Single-cycle strobe: SDA is sampled |

## Verification
The assertions check on every cycle the relations among the strobes and the SCL level. The strobes are never asserted together, each appears only in its own phase, every falling clock starts with a change strobe, disabling releases the line, and no sample is given in the cycle a stretched line comes back high. Phase lengths depend on the baud count, the speed setting and the setup count, so only the bench scenarios can show them. These scenarios are random and directed periods, with and without stretches, that measure the low and released part lengths and the position of the sample strobe, including baud count zero, setup count zero and the high-speed fallback.

// File: rtl/sclGenPkg.sv
package sclGenPkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HIGH  = 2'd2,
    PH_SETUP = 2'd3
  } sclPhase_e;

  localparam logic [1:0] SPD_STD      = 2'd0;
  localparam logic [1:0] SPD_FAST     = 2'd1;
  localparam logic [1:0] SPD_HS       = 2'd2;
  localparam logic [1:0] SPD_FASTPLUS = 2'd3;

  // control -> datapath
  typedef struct packed {
    logic clr;
    logic inc;
  } cntCmd_t;

  // datapath -> control
  typedef struct packed {
    logic zero;
    logic lowDone;
    logic highDone;
    logic setupDone;
  } cntFlag_t;

endpackage

// File: rtl/sclCountPath.sv
module sclCountPath
  import sclGenPkg::*;
#(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         speedMode,
  input  logic [BAUD_W-1:0]  baudCount,
  input  logic [SETUP_W-1:0] setupCount,
  input  cntCmd_t            cmd,
  output cntFlag_t           flags
);
  localparam int CNT_W = (BAUD_W + 1 > SETUP_W) ? BAUD_W + 1 : SETUP_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effBaud;
  logic [CNT_W-1:0] lowLen;
  logic             threePart;

  always_comb begin
    effBaud   = (baudCount == '0) ? CNT_W'(1) : CNT_W'(baudCount);
    threePart = (speedMode == SPD_FAST) || (speedMode == SPD_FASTPLUS);
    lowLen    = threePart ? (effBaud << 1) : effBaud;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        cnt <= '0;
    else if (cmd.clr) cnt <= '0;
    else if (cmd.inc) cnt <= cnt + CNT_W'(1);
  end

  always_comb begin
    flags.zero      = (cnt == '0);
    flags.lowDone   = (cnt == lowLen - CNT_W'(1));
    flags.highDone  = (cnt == effBaud - CNT_W'(1));
    flags.setupDone = (cnt == CNT_W'(setupCount));
  end

endmodule

// File: rtl/sclPhaseCtrl.sv
module sclPhaseCtrl
  import sclGenPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     en,
  input  logic     sclIn,
  input  cntFlag_t flags,
  output cntCmd_t  cmd,
  output logic     sclOut,
  output logic     sdaChange,
  output logic     sdaSample
);
  sclPhase_e phase, phaseNext;
  logic      stretched, stretchedNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      stretched <= 1'b0;
    end else begin
      phase     <= phaseNext;
      stretched <= stretchedNext;
    end
  end

  always_comb begin
    phaseNext     = phase;
    stretchedNext = stretched;
    cmd           = '{clr: 1'b0, inc: 1'b0};
    if (!en) begin
      phaseNext     = PH_IDLE;
      stretchedNext = 1'b0;
      cmd.clr       = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext = PH_LOW;
          cmd.clr   = 1'b1;
        end
        PH_LOW: begin
          if (flags.lowDone) begin
            phaseNext = PH_HIGH;
            cmd.clr   = 1'b1;
          end else begin
            cmd.inc = 1'b1;
          end
        end
        PH_HIGH: begin
          if (flags.zero && !sclIn) begin
            stretchedNext = 1'b1;           // target holds SCL: wait
          end else if (flags.zero && stretched) begin
            phaseNext     = PH_SETUP;
            stretchedNext = 1'b0;
            cmd.clr       = 1'b1;
          end else if (flags.highDone) begin
            phaseNext = PH_LOW;
            cmd.clr   = 1'b1;
          end else begin
            cmd.inc = 1'b1;
          end
        end
        PH_SETUP: begin
          if (flags.setupDone) begin
            phaseNext = PH_HIGH;
            cmd.clr   = 1'b1;
          end else begin
            cmd.inc = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_comb begin
    sclOut    = (phase != PH_LOW);
    sdaChange = (phase == PH_LOW) && flags.zero;
    sdaSample = (phase == PH_HIGH) && flags.zero && sclIn && !stretched;
  end

endmodule

// File: rtl/i2cSclGen.sv
module i2cSclGen
  import sclGenPkg::*;
#(
  parameter int BAUD_W  = 16,
  parameter int SETUP_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               en,
  input  logic [1:0]         speedMode,
  input  logic [BAUD_W-1:0]  baudCount,
  input  logic [SETUP_W-1:0] setupCount,
  input  logic               sclIn,
  output logic               sclOut,
  output logic               sdaChange,
  output logic               sdaSample
);
  cntCmd_t  cmd;
  cntFlag_t flags;

  sclPhaseCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .en        (en),
    .sclIn     (sclIn),
    .flags     (flags),
    .cmd       (cmd),
    .sclOut    (sclOut),
    .sdaChange (sdaChange),
    .sdaSample (sdaSample)
  );

  sclCountPath #(.BAUD_W(BAUD_W), .SETUP_W(SETUP_W)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .speedMode  (speedMode),
    .baudCount  (baudCount),
    .setupCount (setupCount),
    .cmd        (cmd),
    .flags      (flags)
  );

endmodule

// File: rtl/i2cSclGenChk.sv
module i2cSclGenChk (
  input logic clk,
  input logic rstN,
  input logic en,
  input logic sclIn,
  input logic sclOut,
  input logic sdaChange,
  input logic sdaSample
);
  // R1 / R9: disabled generator releases the line, no strobes
  a_r9_disable_release: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> (sclOut && !sdaChange && !sdaSample));

  // R8: strobes are exclusive
  a_r8_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sdaChange, sdaSample}));

  // R8: change strobe only while driven low
  a_r8_change_in_low: assert property (@(posedge clk) disable iff (!rstN)
    sdaChange |-> !sclOut);

  // R8: sample strobe only while released and read high
  a_r8_sample_in_high: assert property (@(posedge clk) disable iff (!rstN)
    sdaSample |-> (sclOut && sclIn));

  // R2: every low part starts with a change strobe
  a_r2_fall_has_change: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> sdaChange);

  // R7: no sample in the cycle a stretched line returns high
  a_r7_setup_after_stretch: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclIn) && sclOut && $past(sclOut)) |-> !sdaSample);

endmodule

bind i2cSclGen i2cSclGenChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .en        (en),
  .sclIn     (sclIn),
  .sclOut    (sclOut),
  .sdaChange (sdaChange),
  .sdaSample (sdaSample)
);

// File: tb/i2cSclGen_test.sv
`timescale 1ns/1ps
module i2cSclGen_test;
  localparam real CLK_NS = 4.0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  speedMode = 2'd0;
  logic [15:0] baudCount = 16'd1;
  logic [15:0] setupCount = 16'd0;
  logic        holdLow = 1'b0;
  logic        sclIn;
  logic        sclOut, sdaChange, sdaSample;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  // open-drain line model: the target can hold SCL low
  assign sclIn = sclOut & ~holdLow;

  i2cSclGen uut (
    .clk(clk), .rstN(rstN), .en(en), .speedMode(speedMode),
    .baudCount(baudCount), .setupCount(setupCount), .sclIn(sclIn),
    .sclOut(sclOut), .sdaChange(sdaChange), .sdaSample(sdaSample)
  );

  function automatic int effB(input int b);
    return (b == 0) ? 1 : b;
  endfunction

  function automatic int expLow(input int m, input int b);
    return (m == 1 || m == 3) ? 2 * effB(b) : effB(b);
  endfunction

  function automatic int expRel(input int b, input int su, input int s);
    return (s == 0) ? effB(b) : s + su + effB(b) + 1;
  endfunction

  function automatic int expSamp(input int su, input int s);
    return (s == 0) ? 0 : s + su + 1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one enabled period; s = stretch length in released cycles (0 or >=2)
  task automatic runCase(input int m, input int b, input int su, input int s);
    int lowN, relN, sampAt, sampCnt, strayChg;
    string tLow;
    tLow = (b == 0) ? "R5" : ((m == 1 || m == 3) ? "R4" : "R3");
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(sclOut && !sdaChange && !sdaSample, "R1 idle released", {sclOut, sdaChange, sdaSample}, 3'b100);
    speedMode = 2'(m); baudCount = 16'(b); setupCount = 16'(su);
    holdLow = (s > 0);
    en = 1'b1;
    @(negedge clk);
    check(!sclOut && sdaChange, "R2 first low with change", {sclOut, sdaChange}, 2'b01);
    lowN = 0; strayChg = 0;
    while (sclOut == 1'b0 && lowN < 200000) begin
      lowN++;
      if (lowN > 1 && sdaChange) strayChg++;
      if (sdaSample) strayChg++;
      @(negedge clk);
    end
    check(lowN == expLow(m, b), {tLow, " low length"}, lowN, expLow(m, b));
    relN = 0; sampAt = -1; sampCnt = 0;
    while (sclOut == 1'b1 && relN < 200000) begin
      if (sdaSample) begin sampCnt++; sampAt = relN; end
      if (sdaChange) strayChg++;
      if (s > 0 && relN == s - 1) holdLow = 1'b0;
      relN++;
      @(negedge clk);
    end
    check(relN == expRel(b, su, s), (s > 0) ? "R6 R7 released length" : {tLow, " high length"},
          relN, expRel(b, su, s));
    check(sampCnt == 1 && sampAt == expSamp(su, s), (s > 0) ? "R7 sample after setup" : "R8 sample first high",
          sampAt, expSamp(su, s));
    check(strayChg == 0, "R8 strobes only in own phase", strayChg, 0);
    check(!sclOut && sdaChange, "R2 next low with change", {sclOut, sdaChange}, 2'b01);
    en = 1'b0;
    @(negedge clk);
    check(sclOut && !sdaChange && !sdaSample, "R9 disable releases", {sclOut, sdaChange, sdaSample}, 3'b100);
  endtask

  initial begin
    void'($urandom(32'd5113));
    repeat (3) @(negedge clk);
    check(sclOut && !sdaChange && !sdaSample, "R1 reset state", {sclOut, sdaChange, sdaSample}, 3'b100);
    rstN = 1'b1;
    // directed corners
    runCase(0, 5, 0, 0);     // R3 standard
    runCase(2, 4, 0, 0);     // R3 high-speed fallback
    runCase(1, 3, 0, 0);     // R4 fast
    runCase(3, 6, 0, 0);     // R4 fast plus
    runCase(0, 0, 0, 0);     // R5 baud zero
    runCase(1, 0, 0, 0);     // R5 baud zero in fast
    runCase(0, 1, 0, 2);     // R6 R7 setup zero
    runCase(3, 2, 4, 5);     // R6 R7 longer stretch
    runCase(1, 300, 7, 0);   // R4 larger count
    // R9: disable in the middle of a low part
    @(negedge clk); speedMode = 2'd1; baudCount = 16'd10; en = 1'b1;
    repeat (5) @(negedge clk);
    check(!sclOut, "R9 mid-low state", sclOut, 0);
    en = 1'b0;
    @(negedge clk);
    check(sclOut && !sdaChange && !sdaSample, "R9 mid-low disable", {sclOut, sdaChange, sdaSample}, 3'b100);
    // random mix
    for (int i = 0; i < 40; i++) begin
      int m, b, su, s;
      m  = int'($urandom % 4);
      b  = int'($urandom % 21);
      su = int'($urandom % 6);
      s  = (($urandom % 3) == 0) ? 2 + int'($urandom % 4) : 0;
      runCase(m, b, su, s);
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule